// File: doc/BRIEF.md
# Single-Bit Alias Remapper

This block sits between one bus master and a word-wide memory. It looks at each request address. If the address falls in one of two alias windows, the block turns the access into an operation on one bit of a word in that window's backing region. One window serves an SRAM range and the other serves a peripheral range. Each window has its own backing base and its own alias base.

Every 32-bit word of an alias window stands for one bit of the backing region:

- **Alias write.** The block reads the target word, changes the addressed bit, and writes the word back. No other request is accepted until the write-back is done.
- **Alias read.** The block returns the addressed bit in bit 0, with all higher bits zero.
- **Other addresses.** All other addresses, including the backing regions themselves, pass through unchanged as full-word accesses.

The upstream side is a valid/ready request port plus a response strobe for reads. The downstream side drives a synchronous memory that returns read data one cycle after the read is issued.

Top module: `bitband_remap`

## Requirements
- R1: A write to an address outside both alias windows is issued to memory in the cycle it is accepted, with the address and the full 32-bit data unchanged.
- R2: A read outside both alias windows returns the whole stored word; rsp_valid is high in the cycle after the request is accepted and at no other time.
- R3: An alias write changes exactly the addressed bit of the target word; the other 31 bits keep their values.
- R4: For an alias offset `off = addr - alias_base`, the target word is `backing_base + 4*floor(off/128)`. The bit index is `off[6:2]`, that is `8*off[6:5] + off[4:2]`. With default parameters, 0x28000000 selects bit 0 of 0x20000000 and 0x2800007C selects bit 31 of 0x20000000.
- R5: On an alias write, bit 0 of the write data becomes the new bit value; bits 31:1 of the write data have no effect.
- R6: An alias read issues one memory read of the target word and returns the selected bit in rsp_rdata bit 0, with bits 31:1 zero.
- R7: An alias write takes exactly two memory cycles. The first is a read of the target word, in the accept cycle. The second is a write of the same address, in the next cycle, during which req_ready is low.
- R8: The peripheral window maps alias base 0x42000000 onto backing base 0x40000000 with the same rule as R4.
- R9: Repeated alias writes to the same bit and to neighbouring bits of one word accumulate, so that later full-word reads match a bit-exact model.
- R10: During and right after reset, req_ready is high, rsp_valid is low and no memory access is issued while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address (word aligned for alias traffic) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
Each internal fault shows up at a specific place and time:

- **Wrong captured bit index or target address.** The write-back drives a second address or flips a second bit, which is visible on the memory port in the cycle right after acceptance. It is also caught later, when a plain read of that word differs from the model.
- **Wrong state after an alias write.** req_ready either stays high during the write-back or stays low for one cycle too many. Either shows up at the next request.
- **Wrong response bookkeeping.** rsp_valid either misses the cycle after a read or appears without one, and the scoreboard sees this at once.

// File: rtl/bitband_remap.sv
module bitband_remap #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS = 32'h2800_0000,
  parameter logic [31:0] PERI_BASE  = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS = 32'h4200_0000,
  parameter int          ALIAS_AW   = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int TW = ALIAS_AW - 7;

  typedef enum logic {S_IDLE, S_WBACK} state_t;
  state_t state;

  logic [31:0] addr_q;
  logic [4:0]  bit_q;
  logic        wbit_q, rsp_pend, rsp_alias;

  logic        hit_s, hit_p, hit, acc, wback;
  logic [31:0] word_off, tgt, mask, merged;

  assign hit_s    = req_addr[31:ALIAS_AW] == SRAM_ALIAS[31:ALIAS_AW];
  assign hit_p    = req_addr[31:ALIAS_AW] == PERI_ALIAS[31:ALIAS_AW];
  assign hit      = hit_s | hit_p;
  assign word_off = {{(32-TW-2){1'b0}}, req_addr[ALIAS_AW-1:7], 2'b00};
  assign tgt      = (hit_s ? SRAM_BASE : PERI_BASE) + word_off;

  assign wback     = state == S_WBACK;
  assign req_ready = !wback;
  assign acc       = req_valid && req_ready;

  assign mask   = 32'd1 << bit_q;
  assign merged = wbit_q ? (mem_rdata | mask) : (mem_rdata & ~mask);

  assign mem_en    = acc || wback;
  assign mem_we    = wback || (acc && req_write && !hit);
  assign mem_addr  = wback ? addr_q : (hit ? tgt : req_addr);
  assign mem_wdata = wback ? merged : req_wdata;

  assign rsp_valid = rsp_pend;
  assign rsp_rdata = rsp_alias ? {31'd0, mem_rdata[bit_q]} : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      bit_q     <= '0;
      wbit_q    <= 1'b0;
      rsp_pend  <= 1'b0;
      rsp_alias <= 1'b0;
    end else begin
      rsp_pend <= acc && !req_write;
      state    <= (acc && req_write && hit) ? S_WBACK : S_IDLE;
      if (acc) begin
        addr_q    <= tgt;
        bit_q     <= req_addr[6:2];
        wbit_q    <= req_wdata[0];
        rsp_alias <= hit;
      end
    end
  end
endmodule

module bitband_remap_chk #(
  parameter logic [31:0] SRAM_ALIAS = 32'h2800_0000,
  parameter logic [31:0] PERI_ALIAS = 32'h4200_0000,
  parameter int          ALIAS_AW   = 25
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        mem_en,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata
);
  logic in_alias, take;
  assign in_alias = (req_addr[31:ALIAS_AW] == SRAM_ALIAS[31:ALIAS_AW]) ||
                    (req_addr[31:ALIAS_AW] == PERI_ALIAS[31:ALIAS_AW]);
  assign take = req_valid && req_ready;

  // R7
  rmw_read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write && in_alias |-> mem_en && !mem_we);
  // R7
  rmw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write && in_alias |=> !req_ready && mem_en && mem_we && mem_addr == $past(mem_addr));
  // R3
  one_bit_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && !req_ready |-> $countones(mem_wdata ^ mem_rdata) <= 1);
  // R1
  pass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write && !in_alias |-> mem_en && mem_we && mem_addr == req_addr && mem_wdata == req_wdata);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_write |=> rsp_valid);
  // R2
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && !req_write) |=> !rsp_valid);
  // R6
  alias_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_write && in_alias |=> rsp_rdata[31:1] == 31'd0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && req_ready |-> !mem_en);
endmodule

bind bitband_remap bitband_remap_chk #(
  .SRAM_ALIAS(SRAM_ALIAS), .PERI_ALIAS(PERI_ALIAS), .ALIAS_AW(ALIAS_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/bitband_remap_bench.sv
module bitband_remap_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  bitband_remap u_bitband_remap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  bit [31:0] mem [int unsigned];
  bit [31:0] refm [int unsigned];
  logic [31:0] rd_q = '0;
  assign mem_rdata = rd_q;
  always @(posedge clk) if (mem_en) begin
    rd_q <= mem[mem_addr[31:2]];
    if (mem_we) mem[mem_addr[31:2]] = mem_wdata;
  end

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit decode(input logic [31:0] a, output logic [31:0] tgt, output int bidx);
    logic [31:0] off, base;
    if (a >= 32'h2800_0000 && a < 32'h2A00_0000) begin off = a - 32'h2800_0000; base = 32'h2000_0000; end
    else if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin off = a - 32'h4200_0000; base = 32'h4000_0000; end
    else begin tgt = a; bidx = 0; return 0; end
    tgt  = base + ((off / 32) & ~32'd3);
    bidx = int'(((off / 32) % 4) * 8 + (off % 32) / 4);
    return 1;
  endfunction

  task automatic drive(input bit wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] t; int b; bit al;
    al = decode(a, t, b);
    drive(1, a, d);
    #1;
    if (al) begin
      chk(mem_en && !mem_we && mem_addr == t, "R7 read phase", mem_addr, t);
      refm[t[31:2]][b] = d[0];
    end else begin
      chk(mem_en && mem_we && mem_addr == a && mem_wdata == d, "R1 pass write", mem_wdata, d);
      refm[a[31:2]] = d;
    end
    @(negedge clk);
    req_valid = 0;
    if (al) chk(!req_ready && mem_en && mem_we && mem_addr == t, "R7 write-back phase", mem_addr, t);
  endtask

  task automatic do_read(input logic [31:0] a, input string tag);
    logic [31:0] t; int b;
    if (decode(a, t, b)) exp_q.push_back({31'd0, refm[t[31:2]][b]});
    else exp_q.push_back(refm[a[31:2]]);
    tag_q.push_back(tag);
    drive(0, a, 32'hDEAD_BEEF);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) if (rst_n && !done && rsp_valid) begin
    if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_rdata, 32'h0);
    else begin
      logic [31:0] e; string tg;
      e = exp_q.pop_front(); tg = tag_q.pop_front();
      chk(rsp_rdata == e, tg, rsp_rdata, e);
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_en, "R10 reset state", {29'd0, req_ready, rsp_valid, mem_en}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_en, "R10 after reset", {29'd0, req_ready, rsp_valid, mem_en}, 32'h4);

    do_write(32'h2000_0000, 32'hFFFF_0000);
    do_read(32'h2000_0000, "R2 full word read");
    do_write(32'h2800_0000, 32'h0000_0001);
    do_read(32'h2000_0000, "R4 bit 0 set only");
    do_write(32'h2800_007C, 32'h0000_0000);
    do_read(32'h2000_0000, "R3 bit 31 cleared only");
    do_write(32'h2800_0040, 32'hFFFF_FFFE);
    do_read(32'h2800_0040, "R5 upper data bits ignored");
    do_read(32'h2000_0000, "R5 word after bit16 write");
    do_write(32'h2800_0084, 32'h1);
    do_read(32'h2000_0004, "R4 second word bit 1");
    do_read(32'h2800_0084, "R6 alias read one");
    do_read(32'h2800_0088, "R6 alias read zero");
    do_write(32'h4000_0008, 32'h1234_5678);
    do_write(32'h4200_0100 + 32'd12, 32'h0);
    do_read(32'h4000_0008, "R8 peripheral window");
    do_read(32'h4200_0100 + 32'd16, "R8 peripheral alias read");
    do_write(32'h1000_0010, 32'hCAFE_F00D);
    do_read(32'h1000_0010, "R9 outside window pass");

    for (int i = 0; i < 400; i++) begin
      int k; logic [31:0] a;
      k = $urandom_range(0, 5);
      a = (k < 3) ? 32'h2800_0000 + 32'($urandom_range(0, 3)) * 128 + 32'($urandom_range(0, 5)) * 4
                  : 32'h4200_0000 + 32'($urandom_range(0, 31)) * 4;
      case (k)
        0, 3: do_write(a, $urandom);
        1: do_read(a, "R6 random alias read");
        2: do_write(32'h2000_0000 + 32'($urandom_range(0, 3)) * 4, $urandom);
        default: do_read(32'h2000_0000 + 32'($urandom_range(0, 3)) * 4, "R9 random word read");
      endcase
    end
    for (int w = 0; w < 4; w++) do_read(32'h2000_0000 + 32'(w) * 4, "R9 final sweep");
    do_read(32'h4000_0000, "R9 final peripheral");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    foreach (refm[k]) chk(mem[k] == refm[k], "R9 memory matches model", mem[k], refm[k]);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule